// File: doc/BRIEF.md
# Alternate-Row Early-Exit SAD Search Evaluator

This block scores candidate positions for block-matching motion estimation. A current 8x8 block of 8-bit unsigned pixels is held on an input bus. Reference candidates arrive one at a time over a valid/ready handshake, each with its horizontal and vertical offset. For each candidate the block first sums absolute differences over the four even rows in a single wide step. That partial sum is compared with the smallest full SAD seen so far in the search. If the partial sum is already at or above that minimum, the candidate is dropped. Otherwise a narrow unit adds the four odd rows, one row per cycle, and the full SAD competes for the minimum.

The first candidate of every search is taken as the predicted-vector candidate. It is always evaluated in full and seeds the minimum, so later candidates hit the early exit more often. A candidate flagged as last closes the search. The block pulses `done` with the best offset and SAD, then treats the next candidate as a new seed. A free-running counter of dropped candidates shows how much work was skipped.

Top module: `altrow_sad_search`

## Requirements
- R1: After reset `cand_ready` is 1, `done` is 0, `skip_count` is 0 and `best_sad` is 0.
- R2: `cand_ready` falls in the cycle after an accepted candidate. It is high again 2 cycles after acceptance for a dropped candidate and 7 cycles after acceptance for a fully evaluated one.
- R3: The first candidate after reset, and the first one after each `done`, is always evaluated in full, and its SAD becomes the minimum whatever its value.
- R4: A non-seed candidate whose even-row sum (rows 0, 2, 4, 6) is greater than or equal to the stored minimum is dropped, including the case of equality. It does not change the minimum, and `skip_count` increases by exactly 1 (wrapping).
- R5: A non-seed candidate whose even-row sum is below the minimum has its odd rows (1, 3, 5, 7) added. Its full SAD replaces the minimum and vector only when it is strictly smaller.
- R6: A candidate whose full SAD equals the stored minimum leaves the stored vector unchanged, so the earlier candidate wins.
- R7: A candidate with `cand_last`=1 makes `done` high for exactly one cycle, in the same cycle that `cand_ready` returns high. In that cycle `best_mvx`, `best_mvy` and `best_sad` hold the search result, including that last candidate.
- R8: After `done`, the minimum from the finished search has no effect. A new seed larger than the previous result still becomes the best.
- R9: `best_sad`, `best_mvx` and `best_mvy` change only in a cycle where `done` is high, and hold their values between searches.
- R10: Pixel (row r, column c) of `cur_blk` and `cand_blk` is at bits [(r*8+c)*8 +: 8]. Offsets are two's-complement signed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_blk | input | 512 | Current block pixels, held stable during a search |
| cand_valid | input | 1 | Candidate present |
| cand_ready | output | 1 | Block can accept a candidate |
| cand_blk | input | 512 | Candidate reference pixels |
| cand_mvx | input | MV_W | Candidate horizontal offset, signed |
| cand_mvy | input | MV_W | Candidate vertical offset, signed |
| cand_last | input | 1 | Final candidate of this search |
| best_mvx | output | MV_W | Winning horizontal offset |
| best_mvy | output | MV_W | Winning vertical offset |
| best_sad | output | 14 | Winning SAD |
| done | output | 1 | One-cycle result pulse |
| skip_count | output | CNT_W | Number of dropped candidates since reset |

## Verification
The candidates are made by shifting the even rows of a ramped current block upward by one amount and the odd rows downward by another. This sets the even-row and odd-row sums independently and also exercises the absolute value in both directions. The patterns include:
- an even-row sum equal to the minimum, which separates a `>=` exit from a `>` exit;
- a small even-row sum with a large odd-row sum, which must be evaluated but must not win;
- a full SAD equal to the minimum, which separates strict replacement from replacement on equality;
- a second search seeded above the first result, which shows whether the minimum is cleared.

The handshake latency of every candidate shows whether it took the short path or the long path.

// File: rtl/altrow_sad_pkg.sv
package altrow_sad_pkg;
  localparam int BLK    = 8;
  localparam int PIX_W  = 8;
  localparam int HALF   = BLK / 2;
  localparam int ROW_W  = BLK * PIX_W;
  localparam int BLK_W  = BLK * ROW_W;
  localparam int HALF_W = HALF * ROW_W;
  localparam int SAD_W  = $clog2(BLK * BLK * ((1 << PIX_W) - 1) + 1);
  localparam int IDX_W  = (HALF > 1) ? $clog2(HALF) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_ODD, ST_FINAL} eval_state_t;

  function automatic logic [PIX_W-1:0] pix_absdiff(input logic [PIX_W-1:0] a,
                                                   input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [SAD_W-1:0] row_sad(input logic [ROW_W-1:0] a,
                                               input logic [ROW_W-1:0] b);
    logic [SAD_W-1:0] acc;
    acc = '0;
    for (int c = 0; c < BLK; c++)
      acc = acc + SAD_W'(pix_absdiff(a[c*PIX_W +: PIX_W], b[c*PIX_W +: PIX_W]));
    return acc;
  endfunction
endpackage

// File: rtl/altrow_even_unit.sv
module altrow_even_unit
  import altrow_sad_pkg::*;
(
  input  logic [HALF_W-1:0] cur_even,
  input  logic [HALF_W-1:0] cand_even,
  output logic [SAD_W-1:0]  even_sum
);
  logic [SAD_W-1:0] per_row [HALF];

  for (genvar r = 0; r < HALF; r++) begin : g_row
    assign per_row[r] = row_sad(cur_even[r*ROW_W +: ROW_W], cand_even[r*ROW_W +: ROW_W]);
  end

  always_comb begin
    even_sum = '0;
    for (int r = 0; r < HALF; r++) even_sum = even_sum + per_row[r];
  end
endmodule

// File: rtl/altrow_odd_unit.sv
module altrow_odd_unit
  import altrow_sad_pkg::*;
(
  input  logic [HALF_W-1:0] cur_odd,
  input  logic [HALF_W-1:0] cand_odd,
  input  logic [IDX_W-1:0]  row_sel,
  output logic [SAD_W-1:0]  row_sum
);
  logic [ROW_W-1:0] cur_row, cand_row;

  always_comb begin
    cur_row  = cur_odd[row_sel*ROW_W +: ROW_W];
    cand_row = cand_odd[row_sel*ROW_W +: ROW_W];
    row_sum  = row_sad(cur_row, cand_row);
  end
endmodule

// File: rtl/altrow_best_tracker.sv
module altrow_best_tracker
  import altrow_sad_pkg::*;
#(
  parameter int MV_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fin_evt,
  input  logic                    seed,
  input  logic [SAD_W-1:0]        full_sad,
  input  logic signed [MV_W-1:0]  mvx,
  input  logic signed [MV_W-1:0]  mvy,
  input  logic                    emit,
  output logic [SAD_W-1:0]        cur_min,
  output logic                    upd_evt,
  output logic [SAD_W-1:0]        best_sad,
  output logic signed [MV_W-1:0]  best_mvx,
  output logic signed [MV_W-1:0]  best_mvy,
  output logic                    done
);
  logic signed [MV_W-1:0] min_mvx, min_mvy;

  assign upd_evt = fin_evt && (seed || (full_sad < cur_min));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_min  <= '1;
      min_mvx  <= '0;
      min_mvy  <= '0;
      best_sad <= '0;
      best_mvx <= '0;
      best_mvy <= '0;
      done     <= 1'b0;
    end else begin
      done <= emit;
      if (upd_evt) begin
        cur_min <= full_sad;
        min_mvx <= mvx;
        min_mvy <= mvy;
      end
      if (emit) begin
        best_sad <= upd_evt ? full_sad : cur_min;
        best_mvx <= upd_evt ? mvx : min_mvx;
        best_mvy <= upd_evt ? mvy : min_mvy;
      end
    end
  end
endmodule

// File: rtl/altrow_sad_search.sv
module altrow_sad_search
  import altrow_sad_pkg::*;
#(
  parameter int MV_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [BLK_W-1:0]       cur_blk,
  input  logic                   cand_valid,
  output logic                   cand_ready,
  input  logic [BLK_W-1:0]       cand_blk,
  input  logic signed [MV_W-1:0] cand_mvx,
  input  logic signed [MV_W-1:0] cand_mvy,
  input  logic                   cand_last,
  output logic signed [MV_W-1:0] best_mvx,
  output logic signed [MV_W-1:0] best_mvy,
  output logic [SAD_W-1:0]       best_sad,
  output logic                   done,
  output logic [CNT_W-1:0]       skip_count
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HALF - 1);

  // Row split: even rows feed the wide unit, odd rows the narrow unit
  logic [HALF_W-1:0] cur_even, cur_odd, cand_even, cand_odd;
  for (genvar h = 0; h < HALF; h++) begin : g_split
    assign cur_even[h*ROW_W +: ROW_W]  = cur_blk[(2*h)*ROW_W +: ROW_W];
    assign cur_odd[h*ROW_W +: ROW_W]   = cur_blk[(2*h+1)*ROW_W +: ROW_W];
    assign cand_even[h*ROW_W +: ROW_W] = cand_blk[(2*h)*ROW_W +: ROW_W];
    assign cand_odd[h*ROW_W +: ROW_W]  = cand_blk[(2*h+1)*ROW_W +: ROW_W];
  end

  eval_state_t            state;
  logic [HALF_W-1:0]      odd_q;
  logic signed [MV_W-1:0] mvx_q, mvy_q;
  logic                   last_q, seed_q;
  logic [SAD_W-1:0]       part_q, acc_q;
  logic [IDX_W-1:0]       row_k;
  logic [SAD_W-1:0]       even_sum, odd_row_sum, cur_min;

  // Named events for the checker
  logic accept, term_evt, cont_evt, fin_evt, upd_evt, emit;

  assign cand_ready = (state == ST_IDLE);
  assign accept     = cand_valid && cand_ready;
  assign term_evt   = (state == ST_CHECK) && !seed_q && (part_q >= cur_min);
  assign cont_evt   = (state == ST_CHECK) && !term_evt;
  assign fin_evt    = (state == ST_FINAL);
  assign emit       = (term_evt || fin_evt) && last_q;

  altrow_even_unit u_even (
    .cur_even (cur_even),
    .cand_even(cand_even),
    .even_sum (even_sum)
  );

  altrow_odd_unit u_odd (
    .cur_odd (cur_odd),
    .cand_odd(odd_q),
    .row_sel (row_k),
    .row_sum (odd_row_sum)
  );

  altrow_best_tracker #(.MV_W(MV_W)) u_best (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin_evt (fin_evt),
    .seed    (seed_q),
    .full_sad(acc_q),
    .mvx     (mvx_q),
    .mvy     (mvy_q),
    .emit    (emit),
    .cur_min (cur_min),
    .upd_evt (upd_evt),
    .best_sad(best_sad),
    .best_mvx(best_mvx),
    .best_mvy(best_mvy),
    .done    (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      odd_q      <= '0;
      mvx_q      <= '0;
      mvy_q      <= '0;
      last_q     <= 1'b0;
      seed_q     <= 1'b1;
      part_q     <= '0;
      acc_q      <= '0;
      row_k      <= '0;
      skip_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          odd_q  <= cand_odd;
          mvx_q  <= cand_mvx;
          mvy_q  <= cand_mvy;
          last_q <= cand_last;
          part_q <= even_sum;
          state  <= ST_CHECK;
        end
        ST_CHECK: begin
          if (term_evt) begin
            skip_count <= skip_count + 1'b1;
            if (last_q) seed_q <= 1'b1;
            state <= ST_IDLE;
          end else if (cont_evt) begin
            acc_q <= part_q;
            row_k <= '0;
            state <= ST_ODD;
          end
        end
        ST_ODD: begin
          acc_q <= acc_q + odd_row_sum;
          row_k <= row_k + 1'b1;
          if (row_k == LAST_IDX) state <= ST_FINAL;
        end
        ST_FINAL: begin
          seed_q <= last_q;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/altrow_sad_checker.sv
module altrow_sad_checker
  import altrow_sad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cand_valid,
  input logic             cand_ready,
  input logic             done,
  input logic [SAD_W-1:0] best_sad,
  input logic [CNT_W-1:0] skip_count,
  input logic             term_evt,
  input logic             fin_evt,
  input logic             upd_evt,
  input logic             seed_q,
  input logic [SAD_W-1:0] cur_min
);
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_ready) |=> !cand_ready);

  p_seed_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && seed_q) |-> upd_evt);

  p_skip_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> (skip_count == CNT_W'($past(skip_count) + 1'b1)));

  p_term_keeps_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> $stable(cur_min));

  p_update_lowers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !seed_q) |=> (cur_min < $past(cur_min)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cand_ready);

  p_best_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(best_sad));
endmodule

bind altrow_sad_search altrow_sad_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cand_valid(cand_valid),
  .cand_ready(cand_ready),
  .done      (done),
  .best_sad  (best_sad),
  .skip_count(skip_count),
  .term_evt  (term_evt),
  .fin_evt   (fin_evt),
  .upd_evt   (upd_evt),
  .seed_q    (seed_q),
  .cur_min   (cur_min)
);

// File: tb/altrow_sad_search_tb.sv
module altrow_sad_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [N*N*8-1:0]   cur_blk = '0;
  logic               cand_valid = 1'b0;
  logic               cand_ready;
  logic [N*N*8-1:0]   cand_blk = '0;
  logic signed [7:0]  cand_mvx = '0, cand_mvy = '0;
  logic               cand_last = 1'b0;
  logic signed [7:0]  best_mvx, best_mvy;
  logic [13:0]        best_sad;
  logic               done;
  logic [15:0]        skip_count;

  int n_chk = 0, n_err = 0;
  int m_min = 0, m_mx = 0, m_my = 0, m_skip = 0;
  bit m_seed = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  altrow_sad_search u_dut (
    .clk(clk), .rst_n(rst_n), .cur_blk(cur_blk),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_blk(cand_blk),
    .cand_mvx(cand_mvx), .cand_mvy(cand_mvy), .cand_last(cand_last),
    .best_mvx(best_mvx), .best_mvy(best_mvy), .best_sad(best_sad),
    .done(done), .skip_count(skip_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int base_pix(input int r, input int c);
    return 100 + ((r * N + c) % 20);
  endfunction

  // Reference SAD over rows of one parity, computed directly by value
  function automatic int ref_rows(input logic [N*N*8-1:0] a, input logic [N*N*8-1:0] b,
                                  input int parity);
    int s = 0;
    for (int r = parity; r < N; r += 2)
      for (int c = 0; c < N; c++) begin
        int pa = int'(a[(r*N+c)*8 +: 8]);
        int pb = int'(b[(r*N+c)*8 +: 8]);
        s += (pa >= pb) ? pa - pb : pb - pa;
      end
    return s;
  endfunction

  // R10: layout of pixel (r,c) at bits [(r*8+c)*8 +: 8]
  task automatic run_cand(input int e, input int o, input int mx, input int my,
                          input bit last, input string tag);
    logic [N*N*8-1:0] blk;
    int part, full, k, exp_k;
    bit term;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        blk[(r*N+c)*8 +: 8] = 8'((r % 2 == 0) ? base_pix(r, c) + e : base_pix(r, c) - o);
    part = ref_rows(cur_blk, blk, 0);
    full = part + ref_rows(cur_blk, blk, 1);
    term = !m_seed && (part >= m_min);
    exp_k = term ? 2 : 7;
    if (term) m_skip++;
    else if (m_seed || full < m_min) begin m_min = full; m_mx = mx; m_my = my; end
    m_seed = last;

    @(negedge clk);
    while (!cand_ready) @(negedge clk);
    cand_blk = blk; cand_mvx = 8'(mx); cand_mvy = 8'(my); cand_last = last;
    cand_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cand_valid = 1'b0;
    k = 1;
    chk(!cand_ready, {tag, " R2 busy after accept"}, cand_ready, 0);
    while (!cand_ready && k < 20) begin @(negedge clk); k++; end
    chk(k == exp_k, {tag, term ? " R4 drop latency" : " R2/R5 full latency"}, k, exp_k);
    chk(done == last, {tag, " R7 done at completion"}, done, last);
    chk(int'(skip_count) == m_skip, {tag, " R4 skip_count"}, skip_count, m_skip);
    if (last) begin
      chk(int'(best_sad) == m_min, {tag, " R7 best_sad"}, best_sad, m_min);
      chk(int'(best_mvx) == m_mx, {tag, " R6 best_mvx"}, best_mvx, m_mx);
      chk(int'(best_mvy) == m_my, {tag, " R6 best_mvy"}, best_mvy, m_my);
      @(negedge clk);
      chk(!done, {tag, " R7 single-cycle done"}, done, 0);
    end
  endtask

  task automatic t_reset();
    #1;
    chk(cand_ready == 1'b1, "R1 ready in reset", cand_ready, 1);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(skip_count == 16'd0, "R1 skip_count in reset", skip_count, 0);
    chk(best_sad == 14'd0, "R1 best_sad in reset", best_sad, 0);
  endtask

  task automatic t_search_a();
    run_cand(3, 3, 1, -1, 0, "A seed R3");
    run_cand(6, 0, 5, 5, 0, "A even==min R4");
    run_cand(7, 0, 6, 6, 0, "A even>min R4");
    run_cand(1, 4, -2, 3, 0, "A lower R5");
    run_cand(2, 3, 7, 7, 0, "A tie R6");
    run_cand(0, 6, 4, 4, 0, "A even low full high R5");
    run_cand(4, 4, 2, 2, 1, "A last R7");
  endtask

  task automatic t_search_b();
    run_cand(5, 5, -3, -4, 0, "B seed above old R8");
    chk(int'(best_sad) == 160, "R9 best held mid-search", best_sad, 160);
    chk(int'(best_mvx) == -2, "R9 best_mvx held mid-search", best_mvx, -2);
    run_cand(10, 0, 9, 9, 1, "B dropped last R7");
  endtask

  task automatic t_search_c();
    run_cand(0, 0, -128, 127, 1, "C lone seed R3 R10");
  endtask

  initial begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        cur_blk[(r*N+c)*8 +: 8] = 8'(base_pix(r, c));
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_search_a();
    t_search_b();
    t_search_c();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule